// File: doc/BRIEF.md
# Video Memory Access Port with Stepping Address

This block places a byte-wide processor register bus in front of a word-organised video memory (16-bit words, 15-bit word address). Software loads a word pointer one byte at a time, then streams data through two byte-wide data ports, one for each half of the word. The pointer advances by itself after each access, so a whole run of the memory can be filled or dumped without reloading it.

Reads are never served straight from the memory. A 16-bit prefetch register holds one word, and every data-port read returns one of its bytes. The register is refilled when the pointer is loaded, and again on every read that advances the pointer. A control register sets which half of the word advances the pointer and sets the step size (1, 32 or 128 words). It also holds a two-bit request for address translation. This block only reports that request on a flag and never applies it.

The bus takes one access per cycle. The block decodes five register offsets: 0 control, 1 pointer low byte, 2 pointer high byte, 3 low data byte, 4 high data byte. Read data is registered.

Top module: `vram_port`

## Requirements
- R1: After reset the pointer, the control register, the prefetch register, the read data output and the translation flag are all zero.
- R2: A write to offset 1 loads pointer bits [7:0], and a write to offset 2 loads pointer bits [14:8] from write data bits [6:0]. Write data bit 7 is dropped, so a read of offset 2 returns bit 7 as zero. Reads of offsets 1 and 2 return the pointer bytes.
- R3: A write to offset 3 stores the byte into the low half (byte address {word,0}) of the word at the pointer. A write to offset 4 stores into the high half ({word,1}).
- R4: Control bit 7 selects which access advances the pointer. At 0, an access to offset 3 advances it. At 1, an access to offset 4 advances it. An access to the other data offset leaves the pointer unchanged.
- R5: Control bits [1:0] set the step: 0 gives +1, 1 gives +32, and 2 or 3 give +128.
- R6: A read of offset 3 returns prefetch bits [7:0] and a read of offset 4 returns bits [15:8]. When the read is the advancing access, the prefetch register is reloaded from the word at the pointer as it stood before the step. That reload shows on the next read, not on this one.
- R7: A write to either pointer offset reloads the prefetch register from the word at the newly written pointer.
- R8: The translation flag is 1 exactly when control bits [3:2] are nonzero. Those bits do not change which words are accessed.
- R9: The pointer wraps modulo 2^15. Stepping from 0x7FFF by 1 gives 0.
- R10: The read data output changes only on a read strobe. Reads of offset 0 return the control register, and reads of offsets 5 to 7 return 0.
- R11: When the write and read strobes are both asserted, only the write is carried out and the read data output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| remap_req | output | 1 | Translation request pending (control bits [3:2] nonzero) |

## Verification
Two things happen in the same clock edge on an advancing read. The byte handed to the bus comes from the prefetch register as it already stood, while that register is refilled from the pre-step pointer. The bench provokes this with back-to-back advancing reads over words that hold different patterns. It expects the first read to repeat the byte already fetched and the following read to return the new word, for both trigger settings. It also asserts both strobes in one cycle. It judges that case from the unchanged read data, from the pointer readback after the write's step, and from the stored byte as seen on a later read.

// File: rtl/vram_pkg.sv
package vram_pkg;

   // Register offsets decoded on the processor bus.
   typedef enum logic [2:0] {
      REG_CTRL    = 3'd0,
      REG_PTR_LO  = 3'd1,
      REG_PTR_HI  = 3'd2,
      REG_DATA_LO = 3'd3,
      REG_DATA_HI = 3'd4
   } vram_reg_e;

   localparam int BYTE_W  = 8;
   localparam int WORD_W  = 16;
   localparam int LANES   = WORD_W / BYTE_W;

   // Control register fields.
   localparam int CTRL_TRIG_BIT = 7;

   // Step amount selected by control bits [1:0].
   function automatic logic [7:0] step_of(input logic [1:0] mode);
      logic [7:0] s;
      case (mode)
         2'd0:    s = 8'd1;
         2'd1:    s = 8'd32;
         default: s = 8'd128;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/vram_addr_ctl.sv
module vram_addr_ctl
   import vram_pkg::*;
#(
   parameter int WORD_AW = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_we,
   input  logic               lo_we,
   input  logic               hi_we,
   input  logic               adv,
   input  logic [BYTE_W-1:0]  wdata,
   output logic [BYTE_W-1:0]  ctrl,
   output logic [WORD_AW-1:0] word_addr,
   output logic [WORD_AW-1:0] next_addr
);

   localparam int HI_W = WORD_AW - BYTE_W;

   logic [WORD_AW-1:0] step_w;

   assign step_w = WORD_AW'(step_of(ctrl[1:0]));

   // Pointer value that holds after this cycle.
   always_comb begin
      next_addr = word_addr;
      if (lo_we)
         next_addr = {word_addr[WORD_AW-1:BYTE_W], wdata};
      else if (hi_we)
         next_addr = {wdata[HI_W-1:0], word_addr[BYTE_W-1:0]};
      else if (adv)
         next_addr = word_addr + step_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_addr <= '0;
         ctrl      <= '0;
      end else begin
         word_addr <= next_addr;
         if (ctrl_we)
            ctrl <= wdata;
      end
   end

endmodule

// File: rtl/vram_store.sv
module vram_store
   import vram_pkg::*;
#(
   parameter int MEM_AW = 10
) (
   input  logic              clk,
   input  logic [LANES-1:0]  lane_we,
   input  logic [MEM_AW-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic [MEM_AW-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_word
);

   localparam int DEPTH = 1 << MEM_AW;

   // One byte-wide array per half of the word.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BYTE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[g])
            cells[wr_addr] <= wr_byte;
      end

      assign rd_word[g*BYTE_W +: BYTE_W] = cells[rd_addr];
   end

endmodule

// File: rtl/vram_readout.sv
module vram_readout
   import vram_pkg::*;
#(
   parameter int WORD_AW = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic [2:0]         sel,
   input  logic               reload,
   input  logic [WORD_W-1:0]  fetch_word,
   input  logic [BYTE_W-1:0]  ctrl,
   input  logic [WORD_AW-1:0] word_addr,
   output logic [BYTE_W-1:0]  rdata
);

   localparam int HI_W = WORD_AW - BYTE_W;

   logic [WORD_W-1:0] prefetch;
   logic [BYTE_W-1:0] rd_mux;

   always_comb begin
      case (sel)
         REG_CTRL:    rd_mux = ctrl;
         REG_PTR_LO:  rd_mux = word_addr[BYTE_W-1:0];
         REG_PTR_HI:  rd_mux = BYTE_W'(word_addr[WORD_AW-1 -: HI_W]);
         REG_DATA_LO: rd_mux = prefetch[BYTE_W-1:0];
         REG_DATA_HI: rd_mux = prefetch[WORD_W-1:BYTE_W];
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prefetch <= '0;
         rdata    <= '0;
      end else begin
         if (reload)
            prefetch <= fetch_word;
         if (rd_en)
            rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/vram_port.sv
module vram_port
   import vram_pkg::*;
#(
   parameter int WORD_AW = 15,
   parameter int MEM_AW  = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   input  logic       bus_wr,
   input  logic       bus_rd,
   output logic [7:0] bus_rdata,
   output logic       remap_req
);

   if (WORD_AW < 9 || WORD_AW > 16) begin : g_bad_word_aw
      $error("vram_port: WORD_AW must lie in 9..16");
   end
   if (MEM_AW < 1 || MEM_AW > WORD_AW) begin : g_bad_mem_aw
      $error("vram_port: MEM_AW must lie in 1..WORD_AW");
   end

   logic               rd_acc;
   logic               hit_lo, hit_hi;
   logic               acc_lo, acc_hi;
   logic               adv;
   logic               ptr_wr;
   logic               reload;
   logic [7:0]         ctrl_q;
   logic [WORD_AW-1:0] word_addr;
   logic [WORD_AW-1:0] next_addr;
   logic [WORD_AW-1:0] fetch_addr;
   logic [WORD_W-1:0]  fetch_word;

   // A write wins when both strobes are raised together.
   assign rd_acc = bus_rd & ~bus_wr;
   assign hit_lo = (bus_addr == REG_DATA_LO);
   assign hit_hi = (bus_addr == REG_DATA_HI);
   assign acc_lo = (bus_wr | rd_acc) & hit_lo;
   assign acc_hi = (bus_wr | rd_acc) & hit_hi;
   assign adv    = ctrl_q[CTRL_TRIG_BIT] ? acc_hi : acc_lo;
   assign ptr_wr = bus_wr & ((bus_addr == REG_PTR_LO) | (bus_addr == REG_PTR_HI));

   // Refill from the new pointer on a pointer load, from the current one
   // on an advancing read.
   assign reload     = ptr_wr | (rd_acc & adv);
   assign fetch_addr = ptr_wr ? next_addr : word_addr;
   assign remap_req  = |ctrl_q[3:2];

   vram_addr_ctl #(.WORD_AW(WORD_AW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (bus_wr & (bus_addr == REG_CTRL)),
      .lo_we     (bus_wr & (bus_addr == REG_PTR_LO)),
      .hi_we     (bus_wr & (bus_addr == REG_PTR_HI)),
      .adv       (adv),
      .wdata     (bus_wdata),
      .ctrl      (ctrl_q),
      .word_addr (word_addr),
      .next_addr (next_addr)
   );

   vram_store #(.MEM_AW(MEM_AW)) u_store (
      .clk     (clk),
      .lane_we ({bus_wr & hit_hi, bus_wr & hit_lo}),
      .wr_addr (word_addr[MEM_AW-1:0]),
      .wr_byte (bus_wdata),
      .rd_addr (fetch_addr[MEM_AW-1:0]),
      .rd_word (fetch_word)
   );

   vram_readout #(.WORD_AW(WORD_AW)) u_read (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (rd_acc),
      .sel        (bus_addr),
      .reload     (reload),
      .fetch_word (fetch_word),
      .ctrl       (ctrl_q),
      .word_addr  (word_addr),
      .rdata      (bus_rdata)
   );

endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk
   import vram_pkg::*;
#(
   parameter int WORD_AW = 15
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         bus_addr,
   input logic [7:0]         bus_wdata,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [7:0]         bus_rdata,
   input logic               remap_req,
   input logic [7:0]         ctrl,
   input logic [WORD_AW-1:0] word_addr
);

   localparam int HI_W = WORD_AW - BYTE_W;

   logic               any_acc;
   logic               trig_acc;
   logic               other_acc;
   logic [WORD_AW-1:0] step_w;

   assign any_acc   = bus_wr | bus_rd;
   assign trig_acc  = any_acc & (ctrl[7] ? (bus_addr == REG_DATA_HI) : (bus_addr == REG_DATA_LO));
   assign other_acc = any_acc & (ctrl[7] ? (bus_addr == REG_DATA_LO) : (bus_addr == REG_DATA_HI));
   assign step_w    = WORD_AW'(step_of(ctrl[1:0]));

   AST_PTR_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_PTR_HI) |=> word_addr[WORD_AW-1 -: HI_W] == $past(bus_wdata[HI_W-1:0])); // R2

   AST_STEP_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      trig_acc |=> word_addr == $past(word_addr) + $past(step_w)); // R5

   AST_NO_STEP_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      other_acc |=> $stable(word_addr)); // R4

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd || bus_wr) |=> $stable(bus_rdata)); // R10

   AST_REMAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_CTRL) |=> remap_req == ($past(bus_wdata[3:2]) != 2'b00)); // R8

endmodule

bind vram_port vram_port_chk #(.WORD_AW(WORD_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .remap_req (remap_req),
   .ctrl      (ctrl_q),
   .word_addr (word_addr)
);

// File: tb/vram_port_test.sv
module vram_port_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       remap_req;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   vram_port uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .remap_req (remap_req)
   );

   // {write, offset[2:0], data, expected}; hex digit 8..C = write offset 0..4,
   // digit 0..4 = read offset 0..4 whose result must equal 'expected'.
   localparam int NVEC = 43;
   localparam logic [19:0] VEC [NVEC] = '{
      20'h8_00_00, 20'h9_10_00, 20'hA_00_00, 20'hC_AA_00, 20'hB_55_00,
      20'hC_BB_00, 20'hB_66_00, 20'h9_10_00, 20'h4_00_AA, 20'h3_00_55,
      20'h3_00_55, 20'h4_00_BB, 20'h1_00_12, 20'h8_81_00, 20'h9_00_00,
      20'hA_00_00, 20'hB_12_00, 20'hC_34_00, 20'hB_78_00, 20'hC_56_00,
      20'h9_00_00, 20'h3_00_12, 20'h4_00_34, 20'h4_00_34, 20'h3_00_78,
      20'h1_00_40, 20'h8_02_00, 20'h9_00_00, 20'hA_01_00, 20'hB_01_00,
      20'h1_00_80, 20'h2_00_01, 20'h8_03_00, 20'hB_02_00, 20'h2_00_02,
      20'h1_00_00, 20'h8_0C_00, 20'h0_00_0C, 20'h9_10_00, 20'hA_00_00,
      20'h3_00_55, 20'h1_00_11, 20'h8_00_00
   };

   function automatic string tag_of(input int i);
      case (i)
         8:              return "R3";
         9:              return "R7";
         10, 11, 21, 24: return "R6";
         12, 22, 23:     return "R4";
         37, 40, 41:     return "R8";
         default:        return "R5";
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic do_op(input logic w, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] q);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = w;
      bus_rd    = ~w;
      @(negedge clk);
      bus_wr = 1'b0;
      bus_rd = 1'b0;
      q = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] q;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1", bus_rdata, 8'h00);
      check("R1", {7'd0, remap_req}, 8'h00);
      do_op(1'b0, 3'd0, 8'h00, q); check("R1", q, 8'h00);
      do_op(1'b0, 3'd1, 8'h00, q); check("R1", q, 8'h00);
      do_op(1'b0, 3'd2, 8'h00, q); check("R1", q, 8'h00);
      do_op(1'b0, 3'd4, 8'h00, q); check("R1", q, 8'h00);

      // Vector table
      for (int i = 0; i < NVEC; i++) begin
         do_op(VEC[i][19], VEC[i][18:16], VEC[i][15:8], q);
         if (!VEC[i][19])
            check(tag_of(i), q, VEC[i][7:0]);
      end

      // R8: flag follows bits [3:2]
      do_op(1'b1, 3'd0, 8'h04, q); check("R8", {7'd0, remap_req}, 8'h01);
      do_op(1'b1, 3'd0, 8'h08, q); check("R8", {7'd0, remap_req}, 8'h01);
      do_op(1'b1, 3'd0, 8'h00, q); check("R8", {7'd0, remap_req}, 8'h00);

      // R2: top bit of high pointer byte dropped
      do_op(1'b1, 3'd2, 8'hFF, q);
      do_op(1'b0, 3'd2, 8'h00, q); check("R2", q, 8'h7F);

      // R9: wrap at 0x7FFF
      do_op(1'b1, 3'd1, 8'hFF, q);
      do_op(1'b0, 3'd1, 8'h00, q); check("R2", q, 8'hFF);
      do_op(1'b1, 3'd3, 8'h00, q);
      do_op(1'b0, 3'd1, 8'h00, q); check("R9", q, 8'h00);
      do_op(1'b0, 3'd2, 8'h00, q); check("R9", q, 8'h00);

      // R11: both strobes, the write alone takes effect
      do_op(1'b1, 3'd1, 8'h11, q);
      do_op(1'b0, 3'd1, 8'h00, q); check("R11", q, 8'h11);
      @(negedge clk);
      bus_addr = 3'd3; bus_wdata = 8'h9C; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      check("R11", bus_rdata, 8'h11);
      do_op(1'b0, 3'd1, 8'h00, q); check("R11", q, 8'h12);

      // R10: output holds through an idle cycle
      @(negedge clk);
      check("R10", bus_rdata, 8'h12);
      do_op(1'b1, 3'd1, 8'h11, q);
      do_op(1'b0, 3'd3, 8'h00, q); check("R11", q, 8'h9C);
      do_op(1'b0, 3'd6, 8'h00, q); check("R10", q, 8'h00);

      finish_run();
   end

endmodule